// File: doc/BRIEF.md
# Shadow-Buffered PWM Timebase

This block is one PWM timebase channel. Software writes four settings through a small write port: a clock divider, a period, a duty compare value and a trigger compare value. Each setting goes into a pending register first. The counter never reads the pending registers directly. It runs from a set of active copies. The active copies are refreshed together, either when the channel is enabled or when a PWM period ends. A write made partway through a period therefore never disturbs the waveform that is being generated.

The counter can count up, count down, or count up and then down. The counting direction is captured when the channel is enabled. Alongside the counter value the block drives one-clock event pulses: period end, counter at zero, duty-compare match while rising, duty-compare match while falling, and the same two matches for the trigger compare. It also drives a PWM waveform built from those matches. A controller writes new settings at any time and uses the period event to know when they took hold.

Top module: `pwm_shadow_timer`

## Requirements
- R1: While reset is asserted, and directly after it, the counter output is 0, the PWM output is low and no event is pulsing. All pending and active settings reset to 0.
- R2: A write with `wr_sel_i` = 0 sets the pending divider from `wr_data_i[11:0]`. Selects 1, 2 and 3 set the pending period, duty compare and trigger compare from all 16 data bits. The counter never uses a pending value directly.
- R3: On the first clock edge with `en_i` high after idle, these things happen at once: all four active settings load from the pending registers, `mode_i` is latched (0 = up, 1 = down, 2 or 3 = up-down), and the counter starts at 0 (up, up-down) or at the new period (down). So the first period uses the freshly loaded values. On an edge with `en_i` low, the counter goes to 0, the PWM output goes low and no events follow.
- R4: The counter steps once every (active divider + 1) clocks. A new divider value first applies to the period after the one in which it was loaded.
- R5: In up mode the counter runs 0 to period. The step taken from the period value completes the period and returns the counter to 0. A period lasts (period + 1) × (divider + 1) clocks.
- R6: In down mode the counter runs from the period value to 0. The step taken from 0 completes the period and reloads the counter with the active period.
- R7: In up-down mode the counter rises from 0 to the period value and then falls. The step that brings it back to 0 completes the period, so a period lasts 2 × period × (divider + 1) clocks. With a period of 0, every step completes a period.
- R8: At every period end all four active settings load from the pending registers. A write made during a period, or on the clock edge that ends it, waits for the following period end. A second write to the same setting before that boundary replaces the first.
- R9: The period event pulses for one clock, in the cycle where the counter shows the first value of a new period. The zero event pulses in each cycle where the counter has just taken the value 0, and that includes the start of counting.
- R10: A match pulses only in the cycle where the counter has just taken a value equal to the active compare. The match is rising in up mode, falling in down mode, and in up-down mode rising on the way up (the peak and the bottom zero count as rising) and falling on the way down. A matching value gives exactly one of the rising or falling events, never both. The trigger compare produces its own pair of events under the same rules.
- R11: In up and up-down modes the PWM output is set at zero and cleared at a rising duty match. In up-down mode it is also set at a falling duty match. In down mode it is set at a falling duty match and cleared at zero. When a set and a clear fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Count direction, latched at enable |
| wr_en_i | input | 1 | Setting write strobe |
| wr_sel_i | input | 2 | Setting select: 0 divider, 1 period, 2 duty compare, 3 trigger compare |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| cnt_up_o | output | 1 | Counter direction, high while rising |
| pwm_o | output | 1 | PWM waveform |
| ev_period_o | output | 1 | Period-end pulse |
| ev_zero_o | output | 1 | Counter-at-zero pulse |
| ev_cmp_up_o | output | 1 | Duty match while rising |
| ev_cmp_dn_o | output | 1 | Duty match while falling |
| ev_trg_up_o | output | 1 | Trigger match while rising |
| ev_trg_dn_o | output | 1 | Trigger match while falling |

## Verification
A write becomes visible in a pending register one edge after its strobe. It reaches the active copies only on the edge that starts counting or ends a period. The counter value, its direction, every event and the PWM level are all registered on the same edge, so each event and PWM change is due in the same cycle as the counter value that caused it. That cycle is one edge after the divider tick, or one edge after enable for the first value. The bench drives on the falling edge and samples just before it. It measures each period from one period pulse to the next, and counts the clocks, the PWM-high clocks and each event inside that window. It then checks those counts against values derived from the period, divider and compare settings. Writes placed at a known offset from a period pulse show whether the period in progress kept its old values.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;

    localparam int unsigned PSC_W_DEF = 12;
    localparam int unsigned CNT_W_DEF = 16;
    localparam int unsigned SLOT_NUM  = 4;
    localparam int unsigned SEL_W     = $clog2(SLOT_NUM);

    // setting slot order is decoded by the write port
    typedef enum logic [SEL_W-1:0] {
        SLOT_DIV  = 2'd0,
        SLOT_PER  = 2'd1,
        SLOT_DUTY = 2'd2,
        SLOT_TRG  = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        DIR_UP     = 2'd0,
        DIR_DOWN   = 2'd1,
        DIR_UPDOWN = 2'd2,
        DIR_ALT    = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int unsigned PSC_W = pwm_shadow_pkg::PSC_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] div_cnt_d, div_cnt_q;

    always_comb begin
        tick_o = run_i && (div_cnt_q == div_i);
        if (!run_i || tick_o) begin
            div_cnt_d = '0;
        end else begin
            div_cnt_d = div_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_cnt_q <= '0;
        end else begin
            div_cnt_q <= div_cnt_d;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> div_cnt_q <= div_i); // R4

endmodule

// File: rtl/pwm_shadow_bank.sv
`timescale 1ns/1ps
module pwm_shadow_bank
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned PSC_W = PSC_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             load_i,
    output logic [PSC_W-1:0] act_div_o,
    output logic [CNT_W-1:0] act_per_o,
    output logic [CNT_W-1:0] act_duty_o,
    output logic [CNT_W-1:0] act_trg_o,
    output logic [CNT_W-1:0] pend_per_o,
    output logic [CNT_W-1:0] pend_duty_o,
    output logic [CNT_W-1:0] pend_trg_o
);
    typedef struct packed {
        logic [SLOT_NUM-1:0][CNT_W-1:0] pend;
        logic [SLOT_NUM-1:0][CNT_W-1:0] act;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load_i) begin
            bank_d.act = bank_q.pend;
        end
        if (wr_en_i) begin
            for (int i = 0; i < int'(SLOT_NUM); i++) begin
                if (wr_sel_i == SEL_W'(i)) begin
                    if (i == int'(SLOT_DIV)) begin
                        bank_d.pend[i] = CNT_W'(wr_data_i[PSC_W-1:0]);
                    end else begin
                        bank_d.pend[i] = wr_data_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_div_o   = bank_q.act[SLOT_DIV][PSC_W-1:0];
    assign act_per_o   = bank_q.act[SLOT_PER];
    assign act_duty_o  = bank_q.act[SLOT_DUTY];
    assign act_trg_o   = bank_q.act[SLOT_TRG];
    assign pend_per_o  = bank_q.pend[SLOT_PER];
    assign pend_duty_o = bank_q.pend[SLOT_DUTY];
    assign pend_trg_o  = bank_q.pend[SLOT_TRG];

    AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(bank_q.act)); // R8
    AST_ACT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> bank_q.act == $past(bank_q.pend)); // R8

endmodule

// File: rtl/pwm_count_core.sv
`timescale 1ns/1ps
module pwm_count_core
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] act_per_i,
    input  logic [CNT_W-1:0] act_duty_i,
    input  logic [CNT_W-1:0] act_trg_i,
    input  logic [CNT_W-1:0] pend_per_i,
    input  logic [CNT_W-1:0] pend_duty_i,
    input  logic [CNT_W-1:0] pend_trg_i,
    output logic             load_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic             pwm_o,
    output logic             ev_period_o,
    output logic             ev_zero_o,
    output logic             ev_cmpu_o,
    output logic             ev_cmpd_o,
    output logic             ev_trgu_o,
    output logic             ev_trgd_o
);
    typedef struct packed {
        logic             run;
        cnt_mode_e        mode;
        logic             up;
        logic [CNT_W-1:0] cnt;
        logic             pwm;
        logic             ev_period;
        logic             ev_zero;
        logic             ev_cmpu;
        logic             ev_cmpd;
        logic             ev_trgu;
        logic             ev_trgd;
    } core_t;

    core_t            s_d, s_q;
    logic             start, fresh, per_end, at_zero, duty_hit, trg_hit;
    logic [CNT_W-1:0] duty_n, trg_n;

    always_comb begin
        s_d           = s_q;
        s_d.ev_period = 1'b0;
        s_d.ev_zero   = 1'b0;
        s_d.ev_cmpu   = 1'b0;
        s_d.ev_cmpd   = 1'b0;
        s_d.ev_trgu   = 1'b0;
        s_d.ev_trgd   = 1'b0;
        start         = en_i && !s_q.run;
        fresh         = 1'b0;
        per_end       = 1'b0;

        if (!en_i) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
            s_d.up  = 1'b1;
            s_d.pwm = 1'b0;
        end else if (start) begin
            fresh    = 1'b1;
            s_d.run  = 1'b1;
            s_d.mode = cnt_mode_e'(mode_i);
            s_d.up   = (cnt_mode_e'(mode_i) != DIR_DOWN);
            s_d.cnt  = (cnt_mode_e'(mode_i) == DIR_DOWN) ? pend_per_i : '0;
            s_d.pwm  = 1'b0;
        end else if (tick_i) begin
            fresh = 1'b1;
            case (s_q.mode)
                DIR_UP: begin
                    if (s_q.cnt >= act_per_i) begin
                        per_end = 1'b1;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (s_q.cnt == '0) begin
                        per_end = 1'b1;
                        s_d.cnt = pend_per_i;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                default: begin
                    if (s_q.up && (s_q.cnt < act_per_i)) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end else if (s_q.up && (act_per_i == '0)) begin
                        per_end = 1'b1;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                        s_d.up  = 1'b0;
                        if (s_q.cnt == CNT_W'(1)) begin
                            per_end = 1'b1;
                            s_d.up  = 1'b1;
                        end
                    end
                end
            endcase
        end

        load_o   = start || per_end;
        duty_n   = load_o ? pend_duty_i : act_duty_i;
        trg_n    = load_o ? pend_trg_i : act_trg_i;
        at_zero  = (s_d.cnt == '0);
        duty_hit = (s_d.cnt == duty_n);
        trg_hit  = (s_d.cnt == trg_n);

        if (fresh) begin
            s_d.ev_period = per_end;
            s_d.ev_zero   = at_zero;
            s_d.ev_cmpu   = s_d.up && duty_hit;
            s_d.ev_cmpd   = !s_d.up && duty_hit;
            s_d.ev_trgu   = s_d.up && trg_hit;
            s_d.ev_trgd   = !s_d.up && trg_hit;
            if (s_d.mode == DIR_DOWN) begin
                if (s_d.ev_cmpd) s_d.pwm = 1'b1;
                if (at_zero)     s_d.pwm = 1'b0;
            end else begin
                if (at_zero || s_d.ev_cmpd) s_d.pwm = 1'b1;
                if (s_d.ev_cmpu)            s_d.pwm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.up   <= 1'b1;
            s_q.mode <= DIR_UP;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o       = s_q.run;
    assign cnt_o       = s_q.cnt;
    assign up_o        = s_q.up;
    assign pwm_o       = s_q.pwm;
    assign ev_period_o = s_q.ev_period;
    assign ev_zero_o   = s_q.ev_zero;
    assign ev_cmpu_o   = s_q.ev_cmpu;
    assign ev_cmpd_o   = s_q.ev_cmpd;
    assign ev_trgu_o   = s_q.ev_trgu;
    assign ev_trgd_o   = s_q.ev_trgd;

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.run |-> !(s_q.ev_period || s_q.ev_zero || s_q.ev_cmpu || s_q.ev_cmpd || s_q.pwm)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run |-> s_q.cnt <= act_per_i); // R5
    AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && en_i && !tick_i) |=> $stable(s_q.cnt)); // R4
    AST_PERIOD_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ev_period && s_q.mode != DIR_DOWN) |-> s_q.cnt == '0); // R7
    AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ev_period && s_q.mode == DIR_DOWN) |-> s_q.cnt == act_per_i); // R6
    AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(s_q.ev_cmpu && s_q.ev_cmpd) && !(s_q.ev_trgu && s_q.ev_trgd)); // R10
    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ev_cmpu && s_q.mode != DIR_DOWN) |-> !s_q.pwm); // R11

endmodule

// File: rtl/pwm_shadow_timer.sv
`timescale 1ns/1ps
module pwm_shadow_timer
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned PSC_W = PSC_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_up_o,
    output logic             pwm_o,
    output logic             ev_period_o,
    output logic             ev_zero_o,
    output logic             ev_cmp_up_o,
    output logic             ev_cmp_dn_o,
    output logic             ev_trg_up_o,
    output logic             ev_trg_dn_o
);
    logic             tick, load, run;
    logic [PSC_W-1:0] act_div;
    logic [CNT_W-1:0] act_per, act_duty, act_trg;
    logic [CNT_W-1:0] pend_per, pend_duty, pend_trg;

    pwm_shadow_bank #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .load_i     (load),
        .act_div_o  (act_div),
        .act_per_o  (act_per),
        .act_duty_o (act_duty),
        .act_trg_o  (act_trg),
        .pend_per_o (pend_per),
        .pend_duty_o(pend_duty),
        .pend_trg_o (pend_trg)
    );

    pwm_prescaler #(.PSC_W(PSC_W)) i_prescaler (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .div_i (act_div),
        .tick_o(tick)
    );

    pwm_count_core #(.CNT_W(CNT_W)) i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .mode_i     (mode_i),
        .tick_i     (tick),
        .act_per_i  (act_per),
        .act_duty_i (act_duty),
        .act_trg_i  (act_trg),
        .pend_per_i (pend_per),
        .pend_duty_i(pend_duty),
        .pend_trg_i (pend_trg),
        .load_o     (load),
        .run_o      (run),
        .cnt_o      (cnt_o),
        .up_o       (cnt_up_o),
        .pwm_o      (pwm_o),
        .ev_period_o(ev_period_o),
        .ev_zero_o  (ev_zero_o),
        .ev_cmpu_o  (ev_cmp_up_o),
        .ev_cmpd_o  (ev_cmp_dn_o),
        .ev_trgu_o  (ev_trg_up_o),
        .ev_trgd_o  (ev_trg_dn_o)
    );

endmodule

// File: tb/test_pwm_shadow_timer.sv
`timescale 1ns/1ps
module test_pwm_shadow_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] cnt;
    logic        cnt_up, pwm, ev_period, ev_zero, ev_cu, ev_cd, ev_tu, ev_td;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_shadow_timer i_pwm_shadow_timer (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cnt_o(cnt), .cnt_up_o(cnt_up), .pwm_o(pwm),
        .ev_period_o(ev_period), .ev_zero_o(ev_zero),
        .ev_cmp_up_o(ev_cu), .ev_cmp_dn_o(ev_cd),
        .ev_trg_up_o(ev_tu), .ev_trg_dn_o(ev_td)
    );

    // mode, divider, period, duty, trigger | len, high, cu, cd, tu, td
    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] div, per, duty, trg;
        logic [15:0] len, high;
        logic [3:0]  cu, cd, tu, td;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{2'd0, 16'd0, 16'd3, 16'd1, 16'd2, 16'd4,  16'd1,  4'd1, 4'd0, 4'd1, 4'd0},
        '{2'd0, 16'd1, 16'd4, 16'd2, 16'd3, 16'd10, 16'd4,  4'd1, 4'd0, 4'd1, 4'd0},
        '{2'd0, 16'd0, 16'd2, 16'd0, 16'd9, 16'd3,  16'd0,  4'd1, 4'd0, 4'd0, 4'd0},
        '{2'd1, 16'd0, 16'd3, 16'd1, 16'd2, 16'd4,  16'd1,  4'd0, 4'd1, 4'd0, 4'd1},
        '{2'd1, 16'd2, 16'd5, 16'd3, 16'd1, 16'd18, 16'd9,  4'd0, 4'd1, 4'd0, 4'd1},
        '{2'd2, 16'd0, 16'd3, 16'd1, 16'd2, 16'd6,  16'd2,  4'd1, 4'd1, 4'd1, 4'd1},
        '{2'd2, 16'd1, 16'd4, 16'd3, 16'd4, 16'd16, 16'd12, 4'd1, 4'd1, 4'd1, 4'd0},
        '{2'd2, 16'd0, 16'd0, 16'd5, 16'd5, 16'd1,  16'd1,  4'd0, 4'd0, 4'd0, 4'd0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seek_period();
        @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            if (ev_period) break;
            @(negedge clk);
        end
    endtask

    // counts clocks from the current sample up to the next period pulse
    task automatic rest(input int n0, output int n, output int tu);
        n = n0; tu = 0;
        while (!ev_period && n < 4000) begin
            tu += int'(ev_tu);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int len, output int hi, output int zr, output int cu,
                           output int cd, output int tu, output int td);
        len = 0; hi = 0; zr = 0; cu = 0; cd = 0; tu = 0; td = 0;
        do begin
            len++;
            hi += int'(pwm); zr += int'(ev_zero);
            cu += int'(ev_cu); cd += int'(ev_cd);
            tu += int'(ev_tu); td += int'(ev_td);
            @(negedge clk);
        end while (!ev_period && len < 4000);
    endtask

    initial begin
        int len, hi, zr, cu, cd, tu, td, n, ntu;
        string lreq;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cnt in reset", int'(cnt), 0);
        check("R1", "pwm/events in reset", int'({pwm, ev_period, ev_zero, ev_cu, ev_cd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cnt after reset", int'(cnt), 0);

        // table walk: R2 slot encoding, R4..R7 period shape, R9..R11 events and waveform
        for (int r = 0; r < 8; r++) begin
            en = 1'b0;
            mode = ROWS[r].mode;
            wr(2'd0, ROWS[r].div);
            wr(2'd1, ROWS[r].per);
            wr(2'd2, ROWS[r].duty);
            wr(2'd3, ROWS[r].trg);
            en = 1'b1;
            seek_period();
            measure(len, hi, zr, cu, cd, tu, td);
            lreq = (ROWS[r].mode == 2'd0) ? "R5" : (ROWS[r].mode == 2'd1) ? "R6" : "R7";
            check(lreq, $sformatf("row %0d period clocks", r), len, int'(ROWS[r].len));
            if (ROWS[r].div != 16'd0)
                check("R4", $sformatf("row %0d divided period", r), len, int'(ROWS[r].len));
            check("R11", $sformatf("row %0d pwm high clocks", r), hi, int'(ROWS[r].high));
            check("R9", $sformatf("row %0d zero events", r), zr, 1);
            check("R10", $sformatf("row %0d duty rising", r), cu, int'(ROWS[r].cu));
            check("R10", $sformatf("row %0d duty falling", r), cd, int'(ROWS[r].cd));
            check("R2", $sformatf("row %0d trigger rising", r), tu, int'(ROWS[r].tu));
            check("R2", $sformatf("row %0d trigger falling", r), td, int'(ROWS[r].td));
        end

        // R3 start loads the pending values before the first count
        en = 1'b0;
        mode = 2'd0;
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd1);
        wr(2'd3, 16'd9);
        check("R3", "idle cnt", int'(cnt), 0);
        en = 1'b1;
        @(negedge clk);
        check("R3", "first cnt", int'(cnt), 0);
        check("R9", "zero at start", int'(ev_zero), 1);
        check("R11", "pwm set at start zero", int'(pwm), 1);
        rest(0, n, ntu);
        check("R3", "first period clocks", n, 4);

        // R8 period write waits for the boundary
        wr(2'd1, 16'd7);
        rest(1, n, ntu);
        check("R8", "period in progress keeps old length", n, 4);
        measure(len, hi, zr, cu, cd, tu, td);
        check("R8", "new period length", len, 8);

        // R8 later write replaces pending one
        wr(2'd1, 16'd5);
        wr(2'd1, 16'd2);
        rest(2, n, ntu);
        check("R8", "period before replaced write", n, 8);
        measure(len, hi, zr, cu, cd, tu, td);
        check("R8", "replaced period length", len, 3);

        // R8 trigger compare loads with the period
        wr(2'd3, 16'd2);
        rest(1, n, ntu);
        check("R8", "no early trigger match", ntu, 0);
        measure(len, hi, zr, cu, cd, tu, td);
        check("R8", "trigger match after load", tu, 1);

        // R4 divider change applies next period
        wr(2'd0, 16'd1);
        rest(1, n, ntu);
        check("R4", "period with old divider", n, 3);
        measure(len, hi, zr, cu, cd, tu, td);
        check("R4", "period with new divider", len, 6);

        // R3 disable clears
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R3", "cnt after disable", int'(cnt), 0);
        check("R3", "pwm/events after disable", int'({pwm, ev_period, ev_zero, ev_cu, ev_cd}), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule